// File: doc/BRIEF.md
# I2C Clock Phase Timer

This block produces the SCL clock of an I2C master from the peripheral clock. Two count registers set the two clock phases. One holds the number of cycles the line is released (the high phase). The other holds the number of cycles it is pulled down (the low phase). The bit period is the sum of the two counts, and the duty cycle follows from their ratio. For example, with a 10 MHz peripheral clock, a sum of 25 gives 400 kHz and a sum of 10 gives 1 MHz.

SCL is driven open-drain style through a pull-down enable. The returning SCL level is checked on every clock edge during the high phase, so a slave that holds the line low lengthens the high phase. Two single-cycle strobes tell a neighbouring byte engine when to sample data (the middle of the high phase) and when to change data (the first cycle of the low phase). A simple write/read port gives access to the two counts. START/STOP, shifting, addressing and arbitration belong to other blocks.

Top module: `scl_timer`

## Requirements
- R1: After reset both count registers read 4, SCL is released (`scl_drive_low` = 0) and both strobes are 0.
- R2: A write to offset 0x10 stores `reg_wdata[15:0]` as the high count, and a write to offset 0x14 stores it as the low count. Bits 31:16 are ignored on a write and read as 0. A read of offset 0x10 or 0x14 returns the stored count. Other offsets read 0, and writes to them change neither count.
- R3: Unless SCL is held low from outside, each high phase lasts exactly the effective high count in clock cycles.
- R4: Each low phase lasts exactly the effective low count in clock cycles (`scl_drive_low` = 1), so the bit period is the sum of the two effective counts.
- R5: The effective count is the stored count, or 4 if the stored count is below 4. A read returns the stored value unclamped.
- R6: A phase uses the count present on the clock edge that starts it. A write during a phase changes only later phases.
- R7: During the high phase, the phase counter advances only on edges where `scl_in` is 1. Each edge that sees `scl_in` = 0 lengthens the phase by one cycle.
- R8: While `en` is 0, SCL is released at once, both strobes are 0, and the phase state is cleared. On the first edge that sees `en` = 1, a full low phase starts.
- R9: `change_stb` is 1 for exactly the first cycle of each low phase.
- R10: `sample_stb` is 1 in the high phase on the cycle where `scl_in` is 1 and floor(N/2) counted cycles have already elapsed, with N the effective high count of that phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Clock generation enable |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| scl_in | input | 1 | Level of the SCL line |
| scl_drive_low | output | 1 | 1 pulls SCL down, 0 releases it |
| sample_stb | output | 1 | Mid-high-phase data sampling strobe |
| change_stb | output | 1 | Low-phase start data change strobe |

## Verification
Register writes land on the edge that ends the write cycle. Reads are combinational, so they are checked in the same cycle the address is presented. `scl_drive_low` and both strobes are due in the cycle after the edge that moves the phase state. Releasing on a falling `en` and the `sample_stb` gating by `scl_in` take effect within the same cycle. A behavioural model in the bench advances on the same edge and is compared with all three outputs in the second half of every cycle, after the inputs have settled. Phase lengths are also measured from `scl_drive_low` run lengths, and these are checked against the programmed counts, including a write in mid-phase and an externally stretched high phase.

// File: rtl/scl_timer.sv
`timescale 1ns/1ps
module scl_timer #(
  parameter int CNT_W   = 16,
  parameter int MIN_CNT = 4,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter logic [ADDR_W-1:0] HI_OFFSET = 'h10,
  parameter logic [ADDR_W-1:0] LO_OFFSET = 'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              scl_in,
  output logic              scl_drive_low,
  output logic              sample_stb,
  output logic              change_stb
);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_CNT);

  logic [CNT_W-1:0] hi_q, lo_q, hi_eff, lo_eff, cnt, len;
  logic running, phase_hi, ph_end, active;

  assign hi_eff = (hi_q < MIN_V) ? MIN_V : hi_q;
  assign lo_eff = (lo_q < MIN_V) ? MIN_V : lo_q;
  assign ph_end = (cnt == len - 1'b1);
  assign active = en & running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= MIN_V;
      lo_q <= MIN_V;
    end else if (reg_we) begin
      if (reg_addr == HI_OFFSET) hi_q <= reg_wdata[CNT_W-1:0];
      else if (reg_addr == LO_OFFSET) lo_q <= reg_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == HI_OFFSET) reg_rdata[CNT_W-1:0] = hi_q;
    else if (reg_addr == LO_OFFSET) reg_rdata[CNT_W-1:0] = lo_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      phase_hi <= 1'b0;
      cnt      <= '0;
      len      <= MIN_V;
    end else if (!en) begin
      running  <= 1'b0;
      phase_hi <= 1'b0;
      cnt      <= '0;
    end else if (!running) begin
      running  <= 1'b1;
      phase_hi <= 1'b0;
      cnt      <= '0;
      len      <= lo_eff;
    end else if (!phase_hi) begin
      if (ph_end) begin
        phase_hi <= 1'b1;
        cnt      <= '0;
        len      <= hi_eff;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (scl_in) begin
      if (ph_end) begin
        phase_hi <= 1'b0;
        cnt      <= '0;
        len      <= lo_eff;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign scl_drive_low = active & ~phase_hi;
  assign change_stb    = active & ~phase_hi & (cnt == '0);
  assign sample_stb    = active & phase_hi & scl_in & (cnt == (len >> 1));
endmodule

module scl_timer_sva #(
  parameter int CNT_W   = 16,
  parameter int MIN_CNT = 4,
  parameter int DATA_W  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             scl_in,
  input logic             scl_drive_low,
  input logic             sample_stb,
  input logic             change_stb,
  input logic [DATA_W-1:0] reg_rdata,
  input logic             running,
  input logic             phase_hi,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] len
);
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:CNT_W] == '0);
  a_r5_len_min: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> len >= CNT_W'(MIN_CNT));
  a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> cnt < len);
  a_r7_stretch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && running && phase_hi && !scl_in) |=> $stable(cnt) && phase_hi);
  a_r8_released: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !scl_drive_low && !sample_stb && !change_stb);
  a_r8_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !running && cnt == '0);
  a_r9_single: assert property (@(posedge clk) disable iff (!rst_n)
    change_stb |=> !change_stb);
  a_r9_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    change_stb |-> scl_drive_low);
  a_r10_in_high: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> !scl_drive_low && scl_in && !change_stb);
endmodule

bind scl_timer scl_timer_sva #(.CNT_W(CNT_W), .MIN_CNT(MIN_CNT), .DATA_W(DATA_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .en(en), .scl_in(scl_in),
  .scl_drive_low(scl_drive_low), .sample_stb(sample_stb), .change_stb(change_stb),
  .reg_rdata(reg_rdata), .running(running), .phase_hi(phase_hi), .cnt(cnt), .len(len)
);

// File: tb/scl_timer_bench.sv
`timescale 1ns/1ps
module scl_timer_bench;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, reg_we = 1'b0, stretch = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic scl_in, scl_drive_low, sample_stb, change_stb;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;
  assign scl_in = ~scl_drive_low & ~stretch;

  scl_timer u_scl_timer (
    .clk(clk), .rst_n(rst_n), .en(en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_in(scl_in),
    .scl_drive_low(scl_drive_low), .sample_stb(sample_stb), .change_stb(change_stb));

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference
  int m_hi = 4, m_lo = 4, m_run = 0, m_ph = 0, m_pos = 0, m_len = 4;
  function automatic int eff(input int v);
    return (v < 4) ? 4 : v;
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      if (!en) begin
        m_run = 0; m_ph = 0; m_pos = 0;
      end else if (m_run == 0) begin
        m_run = 1; m_ph = 0; m_pos = 0; m_len = eff(m_lo);
      end else if (m_ph == 0 || scl_in) begin
        m_pos++;
        if (m_pos == m_len) begin
          m_ph = 1 - m_ph; m_pos = 0;
          m_len = (m_ph == 1) ? eff(m_hi) : eff(m_lo);
        end
      end
      if (reg_we && reg_addr == 8'h10) m_hi = int'(reg_wdata[15:0]);
      if (reg_we && reg_addr == 8'h14) m_lo = int'(reg_wdata[15:0]);
    end
  end

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      bit act;
      act = en && m_run == 1;
      check("R4", "scl_drive_low", scl_drive_low, act && m_ph == 0);
      check("R9", "change_stb", change_stb, act && m_ph == 0 && m_pos == 0);
      check("R10", "sample_stb", sample_stb, act && m_ph == 1 && scl_in && m_pos == m_len / 2);
    end
  end

  // phase length monitor
  int cur_run = 0, last_low = 0, last_high = 0;
  logic prev_dl = 1'b0;
  always @(negedge clk) begin
    #2;
    if (!en) begin
      cur_run = 0; prev_dl = 1'b0;
    end else if (scl_drive_low == prev_dl) begin
      cur_run++;
    end else begin
      if (prev_dl) last_low = cur_run; else last_high = cur_run;
      cur_run = 1; prev_dl = scl_drive_low;
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    check(req, $sformatf("read 0x%0h", a), reg_rdata, exp);
  endtask

  task automatic wait_level(input logic v);
    do begin @(negedge clk); #1; end while (scl_drive_low != v);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cycles(3);
    rst_n = 1'b1;
    @(negedge clk);
    rd("R1", 8'h10, 32'd4);
    rd("R1", 8'h14, 32'd4);
    check("R1", "scl released", scl_drive_low, 0);
    check("R1", "strobes idle", {sample_stb, change_stb}, 0);

    en = 1'b1;
    cycles(40);
    check("R4", "default low len", last_low, 4);
    check("R3", "default high len", last_high, 4);

    wr(8'h10, 32'd7);
    wr(8'h14, 32'd12);
    rd("R2", 8'h10, 32'd7);
    rd("R2", 8'h14, 32'd12);
    cycles(60);
    check("R4", "low len 12", last_low, 12);
    check("R3", "high len 7", last_high, 7);
    check("R4", "bit period", last_low + last_high, 19);

    wr(8'h10, 32'hABCD_0009);
    rd("R2", 8'h10, 32'h0000_0009);
    wr(8'h18, 32'd33);
    rd("R2", 8'h18, 32'd0);
    rd("R2", 8'h10, 32'd9);
    rd("R2", 8'h14, 32'd12);

    wr(8'h10, 32'd1);
    wr(8'h14, 32'd0);
    rd("R5", 8'h10, 32'd1);
    rd("R5", 8'h14, 32'd0);
    cycles(50);
    check("R5", "clamped low len", last_low, 4);
    check("R5", "clamped high len", last_high, 4);

    wr(8'h10, 32'd5);
    wr(8'h14, 32'd5);
    cycles(30);
    do begin @(negedge clk); #1; end while (!change_stb);
    wr(8'h14, 32'd9);
    cycles(5);
    check("R6", "running low keeps old len", last_low, 5);
    cycles(30);
    check("R6", "next low uses new len", last_low, 9);

    wr(8'h10, 32'd6);
    wr(8'h14, 32'd6);
    cycles(30);
    wait_level(1'b1);
    wait_level(1'b0);
    stretch = 1'b1;
    cycles(5);
    stretch = 1'b0;
    cycles(10);
    check("R7", "stretched high len", last_high, 11);
    cycles(30);
    check("R7", "unstretched high len", last_high, 6);

    cycles(3);
    @(negedge clk);
    en = 1'b0;
    #1;
    check("R8", "release on disable", scl_drive_low, 0);
    check("R8", "strobes off on disable", {sample_stb, change_stb}, 0);
    cycles(4);
    check("R8", "still released", scl_drive_low, 0);
    en = 1'b1;
    @(negedge clk); #1;
    check("R8", "first phase is low", scl_drive_low, 1);
    check("R9", "strobe on first low", change_stb, 1);
    cycles(10);
    check("R8", "first low full len", last_low, 6);

    wr(8'h10, 32'd300);
    wr(8'h14, 32'd200);
    cycles(1200);
    check("R4", "long low len", last_low, 200);
    check("R3", "long high len", last_high, 300);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule